// File: doc/BRIEF.md
# CPU Address Router with Shared Wide-RAM Arbitration

This block sits between a 32-bit CPU load/store port and the targets behind it. These are a boot ROM, a main RAM organised as 128-bit words, a DMA channel register page and an interrupt controller register page. Every CPU access is routed from its physical address. Reads are answered one cycle later, with the correct 32-bit slice of whatever the target returned. Narrow CPU stores into the wide RAM are converted into a 16-bit byte-enable write that leaves the other bytes of the word untouched. Any read that hits no target is answered with a recognisable poison word.

The RAM has one read port and one write port, and other agents share them. A DMA engine reads whole 128-bit words through the read port. An egress agent writes masked 128-bit words through the write port. The CPU always has priority, so it never stalls. A DMA or egress requester that is refused keeps its request raised. It is granted in the first cycle in which the CPU does not use that RAM port. DMA reads and egress writes never block each other.

The CPU address reaches physical space by dropping its top three bits. RAM and ROM sizes are parameters, and an address past the end of RAM is unmapped rather than wrapped.

Top module: `soc_addr_router`

## Requirements
- R1: A CPU read of RAM returns bits [32*k+31:32*k] of the addressed 128-bit word, where k is address bits [3:2]. The data appears on `cpu_rdata` with `cpu_rvalid` high in the cycle after the request.
- R2: A CPU write to RAM puts `cpu_wdata` on every 32-bit lane of `ram_wr_data`. It drives `ram_wr_be` with `cpu_be` in bits [4k+3:4k] and zeros elsewhere, so bytes that are not addressed keep their value.
- R3: When a CPU RAM read and a DMA read request occur in the same cycle, the CPU address drives `ram_rd_addr` and `dma_gnt` stays low.
- R4: When a CPU RAM write and an egress write request occur in the same cycle, the CPU drives the RAM write port and `eg_gnt` stays low.
- R5: A DMA or egress request that stays raised is granted in the first cycle in which the CPU does not use that port. DMA and egress grants never block each other. DMA read data appears on `dma_rdata` with `dma_rvalid` high in the cycle after the grant.
- R6: Physical bits [28:12] equal to 17'h1_000A select the DMA register page. A read raises `dmac_rd_en`, a write raises `dmac_wr_en`, and `dmac_off` carries bits [11:0]. The read data returns one cycle later.
- R7: Physical bits [28:12] equal to 17'h1_000F select the interrupt page. Offset 0x000 selects the status register (`intc_sel`=0) and offset 0x010 selects the mask register (`intc_sel`=1). Any other offset in that page is unmapped.
- R8: A read of an unmapped address returns 32'hDEADBEEF one cycle later. A write to an unmapped address raises no write strobe.
- R9: Physical addresses from 29'h1FC0_0000 up to the ROM size (CPU address 32'hBFC0_0000 is its first word) read the ROM at word index (physical − base)/4. Writes there raise no strobe.
- R10: Physical addresses at or above `RAM_BYTES` do not reach the RAM: reads return the poison word and writes are dropped.
- R11: The physical address is CPU address bits [28:0], so CPU addresses that differ only in bits [31:29] reach the same location.
- R12: While reset is asserted, `cpu_rvalid` and `dma_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU byte address |
| cpu_be | input | 4 | Byte enables of the 32-bit store |
| cpu_wdata | input | 32 | Store data |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 32 | Load data |
| dma_req | input | 1 | DMA read request (held until granted) |
| dma_qaddr | input | RAM_AW | DMA word index |
| dma_gnt | output | 1 | DMA request issued this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 128 | DMA read data |
| eg_req | input | 1 | Egress write request (held until granted) |
| eg_qaddr | input | RAM_AW | Egress word index |
| eg_be | input | 16 | Egress byte enables |
| eg_data | input | 128 | Egress write data |
| eg_gnt | output | 1 | Egress write issued this cycle |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rd_addr | output | RAM_AW | RAM read word index |
| ram_rd_data | input | 128 | RAM read data, one cycle after strobe |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | RAM_AW | RAM write word index |
| ram_wr_be | output | 16 | RAM byte enables |
| ram_wr_data | output | 128 | RAM write data |
| rom_rd_en | output | 1 | ROM read strobe |
| rom_rd_addr | output | ROM_AW | ROM word index |
| rom_rd_data | input | 32 | ROM data, one cycle after strobe |
| dmac_rd_en | output | 1 | DMA register read strobe |
| dmac_wr_en | output | 1 | DMA register write strobe |
| dmac_off | output | 12 | Offset within the DMA page |
| dmac_wdata | output | 32 | DMA register write data |
| dmac_rdata | input | 32 | DMA register read data, one cycle after strobe |
| intc_rd_en | output | 1 | Interrupt register read strobe |
| intc_wr_en | output | 1 | Interrupt register write strobe |
| intc_sel | output | 1 | 0 = status, 1 = mask |
| intc_wdata | output | 32 | Interrupt register write data |
| intc_rdata | input | 32 | Interrupt register read data, one cycle after strobe |

## Verification
The only state in this block is the registered source and lane of the last CPU read, plus the two valid flags. If that state is wrong, the very next cycle shows a wrong slice, a wrong target's data or a missing valid. Decode and priority are purely combinational. A decode error therefore shows in the same cycle as a strobe on the wrong port, or as a missing grant. A masking error shows only when the word is read back later, so stores are followed by lane-by-lane reads against a shadow copy of RAM. Contention is driven with both agents in the same cycle, and the grant is then observed in the following cycle.

// File: rtl/soc_route_pkg.sv
package soc_route_pkg;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_ROM  = 3'd2,
    TGT_DMAC = 3'd3,
    TGT_INTC = 3'd4
  } tgt_e;

  localparam logic [16:0] DMAC_PAGE     = 17'h1_000A;
  localparam logic [16:0] INTC_PAGE     = 17'h1_000F;
  localparam logic [11:0] INTC_OFF_STAT = 12'h000;
  localparam logic [11:0] INTC_OFF_MASK = 12'h010;
  localparam logic [32:0] ROM_BASE      = 33'h0_1FC0_0000;
  localparam logic [31:0] POISON_WORD   = 32'hDEAD_BEEF;

endpackage

// File: rtl/soc_route_decode.sv
module soc_route_decode
  import soc_route_pkg::*;
#(
  parameter int RAM_BYTES = 32'h0200_0000,
  parameter int ROM_BYTES = 32'h0040_0000,
  parameter int DW        = 128,
  localparam int LANES    = DW / 32,
  localparam int LB       = $clog2(LANES),
  localparam int RAM_AW   = $clog2(RAM_BYTES / (DW / 8)),
  localparam int ROM_AW   = $clog2(ROM_BYTES / 4)
) (
  input  logic [28:0]       phys,
  output tgt_e              tgt,
  output logic [RAM_AW-1:0] ram_idx,
  output logic [LB-1:0]     lane,
  output logic [ROM_AW-1:0] rom_widx,
  output logic [11:0]       off,
  output logic              intc_sel
);

  localparam logic [32:0] RAM_LIMIT = 33'(RAM_BYTES);
  localparam logic [32:0] ROM_END   = ROM_BASE + 33'(ROM_BYTES);

  logic [32:0] phys_w;
  logic        in_ram;
  logic        in_rom;
  logic        in_dmac;
  logic        in_intc;

  assign phys_w   = {4'b0, phys};
  assign off      = phys[11:0];
  assign ram_idx  = phys[RAM_AW+LB+1:LB+2];
  assign lane     = phys[LB+1:2];
  assign rom_widx = phys[ROM_AW+1:2];
  assign intc_sel = phys[4];

  always_comb begin
    in_ram  = phys_w < RAM_LIMIT;
    in_rom  = (phys_w >= ROM_BASE) && (phys_w < ROM_END);
    in_dmac = phys[28:12] == DMAC_PAGE;
    in_intc = (phys[28:12] == INTC_PAGE) &&
              ((phys[11:0] == INTC_OFF_STAT) || (phys[11:0] == INTC_OFF_MASK));
  end

  always_comb begin
    tgt = TGT_NONE;
    if (in_ram)       tgt = TGT_RAM;
    else if (in_rom)  tgt = TGT_ROM;
    else if (in_dmac) tgt = TGT_DMAC;
    else if (in_intc) tgt = TGT_INTC;
  end

endmodule

// File: rtl/soc_ram_arb.sv
module soc_ram_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_rd,
  input  logic cpu_wr,
  input  logic dma_req,
  input  logic eg_req,
  output logic dma_gnt,
  output logic eg_gnt,
  output logic dma_rvalid
);

  logic dma_rvalid_d;

  always_comb begin
    dma_gnt      = dma_req & ~cpu_rd;
    eg_gnt       = eg_req & ~cpu_wr;
    dma_rvalid_d = dma_gnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_rvalid <= 1'b0;
    else        dma_rvalid <= dma_rvalid_d;
  end

  // R3: the read port serves at most one agent per cycle
  a_r3_read_port_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_rd, dma_gnt}));

  // R4: the write port serves at most one agent per cycle
  a_r4_write_port_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_wr, eg_gnt}));

  // R5: an uncontended DMA request is served at once
  a_r5_idle_port_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !cpu_rd) |-> dma_gnt);

  // R5: every DMA grant is answered in the next cycle
  a_r5_dma_return: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |=> dma_rvalid);

endmodule

// File: rtl/soc_read_return.sv
module soc_read_return
  import soc_route_pkg::*;
#(
  parameter int DW     = 128,
  localparam int LANES = DW / 32,
  localparam int LB    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_accept,
  input  tgt_e          tgt_in,
  input  logic [LB-1:0] lane_in,
  input  logic [DW-1:0] ram_rd_data,
  input  logic [31:0]   rom_rd_data,
  input  logic [31:0]   dmac_rdata,
  input  logic [31:0]   intc_rdata,
  output logic          rvalid,
  output logic [31:0]   rdata
);

  tgt_e          src_q, src_d;
  logic [LB-1:0] lane_q, lane_d;
  logic          rvalid_d;
  logic          cap_en;

  always_comb begin
    cap_en   = rd_accept;
    src_d    = cap_en ? tgt_in : src_q;
    lane_d   = cap_en ? lane_in : lane_q;
    rvalid_d = rd_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= TGT_NONE;
      lane_q <= '0;
      rvalid <= 1'b0;
    end else begin
      src_q  <= src_d;
      lane_q <= lane_d;
      rvalid <= rvalid_d;
    end
  end

  always_comb begin
    unique case (src_q)
      TGT_RAM:  rdata = ram_rd_data[{lane_q, 5'd0} +: 32];
      TGT_ROM:  rdata = rom_rd_data;
      TGT_DMAC: rdata = dmac_rdata;
      TGT_INTC: rdata = intc_rdata;
      default:  rdata = POISON_WORD;
    endcase
  end

  // R1: every accepted load is answered in the next cycle
  a_r1_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> rvalid);

  // R12: no valid without a load in the cycle before
  a_r12_quiet_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_accept |=> !rvalid);

  // R8: an answer from no target carries the poison word
  a_r8_poison_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && src_q == TGT_NONE) |-> rdata == POISON_WORD);

endmodule

// File: rtl/soc_addr_router.sv
module soc_addr_router
  import soc_route_pkg::*;
#(
  parameter int RAM_BYTES = 32'h0200_0000,
  parameter int ROM_BYTES = 32'h0040_0000,
  parameter int DW        = 128,
  localparam int LANES    = DW / 32,
  localparam int LB       = $clog2(LANES),
  localparam int BEW      = DW / 8,
  localparam int RAM_AW   = $clog2(RAM_BYTES / BEW),
  localparam int ROM_AW   = $clog2(ROM_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [3:0]        cpu_be,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_rvalid,
  output logic [31:0]       cpu_rdata,
  input  logic              dma_req,
  input  logic [RAM_AW-1:0] dma_qaddr,
  output logic              dma_gnt,
  output logic              dma_rvalid,
  output logic [DW-1:0]     dma_rdata,
  input  logic              eg_req,
  input  logic [RAM_AW-1:0] eg_qaddr,
  input  logic [BEW-1:0]    eg_be,
  input  logic [DW-1:0]     eg_data,
  output logic              eg_gnt,
  output logic              ram_rd_en,
  output logic [RAM_AW-1:0] ram_rd_addr,
  input  logic [DW-1:0]     ram_rd_data,
  output logic              ram_wr_en,
  output logic [RAM_AW-1:0] ram_wr_addr,
  output logic [BEW-1:0]    ram_wr_be,
  output logic [DW-1:0]     ram_wr_data,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_rd_addr,
  input  logic [31:0]       rom_rd_data,
  output logic              dmac_rd_en,
  output logic              dmac_wr_en,
  output logic [11:0]       dmac_off,
  output logic [31:0]       dmac_wdata,
  input  logic [31:0]       dmac_rdata,
  output logic              intc_rd_en,
  output logic              intc_wr_en,
  output logic              intc_sel,
  output logic [31:0]       intc_wdata,
  input  logic [31:0]       intc_rdata
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_s1, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_int_n = rst_s1;

  logic unused_seg;
  assign unused_seg = ^cpu_addr[31:29];

  tgt_e              tgt;
  logic [RAM_AW-1:0] cpu_idx;
  logic [LB-1:0]     cpu_lane;
  logic [ROM_AW-1:0] rom_widx;
  logic [11:0]       reg_off;
  logic              reg_sel;

  soc_route_decode #(
    .RAM_BYTES(RAM_BYTES), .ROM_BYTES(ROM_BYTES), .DW(DW)
  ) u_dec (
    .phys(cpu_addr[28:0]), .tgt(tgt), .ram_idx(cpu_idx), .lane(cpu_lane),
    .rom_widx(rom_widx), .off(reg_off), .intc_sel(reg_sel)
  );

  logic cpu_rd, cpu_wr, cpu_ram_rd, cpu_ram_wr;

  always_comb begin
    cpu_rd     = cpu_req & ~cpu_we;
    cpu_wr     = cpu_req & cpu_we;
    cpu_ram_rd = cpu_rd & (tgt == TGT_RAM);
    cpu_ram_wr = cpu_wr & (tgt == TGT_RAM);
  end

  soc_ram_arb u_arb (
    .clk(clk), .rst_n(rst_int_n), .cpu_rd(cpu_ram_rd), .cpu_wr(cpu_ram_wr),
    .dma_req(dma_req), .eg_req(eg_req), .dma_gnt(dma_gnt), .eg_gnt(eg_gnt),
    .dma_rvalid(dma_rvalid)
  );

  // narrow store placed into its lane of the wide word
  logic [BEW-1:0] cpu_be_w;
  logic [DW-1:0]  cpu_wdata_w;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign cpu_be_w[4*k +: 4]     = (cpu_lane == LB'(k)) ? cpu_be : 4'b0;
    assign cpu_wdata_w[32*k +: 32] = cpu_wdata;
  end

  always_comb begin
    ram_rd_en   = cpu_ram_rd | dma_gnt;
    ram_rd_addr = cpu_ram_rd ? cpu_idx : dma_qaddr;
    ram_wr_en   = cpu_ram_wr | eg_gnt;
    ram_wr_addr = cpu_ram_wr ? cpu_idx : eg_qaddr;
    ram_wr_be   = cpu_ram_wr ? cpu_be_w : eg_be;
    ram_wr_data = cpu_ram_wr ? cpu_wdata_w : eg_data;
    dma_rdata   = ram_rd_data;

    rom_rd_en   = cpu_rd & (tgt == TGT_ROM);
    rom_rd_addr = rom_widx;

    dmac_rd_en  = cpu_rd & (tgt == TGT_DMAC);
    dmac_wr_en  = cpu_wr & (tgt == TGT_DMAC);
    dmac_off    = reg_off;
    dmac_wdata  = cpu_wdata;

    intc_rd_en  = cpu_rd & (tgt == TGT_INTC);
    intc_wr_en  = cpu_wr & (tgt == TGT_INTC);
    intc_sel    = reg_sel;
    intc_wdata  = cpu_wdata;
  end

  soc_read_return #(.DW(DW)) u_ret (
    .clk(clk), .rst_n(rst_int_n), .rd_accept(cpu_rd), .tgt_in(tgt),
    .lane_in(cpu_lane), .ram_rd_data(ram_rd_data), .rom_rd_data(rom_rd_data),
    .dmac_rdata(dmac_rdata), .intc_rdata(intc_rdata),
    .rvalid(cpu_rvalid), .rdata(cpu_rdata)
  );

  // R8: a store to nowhere leaves every write port to the other agents
  a_r8_unmapped_write_silent: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_wr && tgt == TGT_NONE) |-> (!dmac_wr_en && !intc_wr_en && (ram_wr_en == eg_gnt)));

  // R2: a CPU store enables exactly as many RAM bytes as the CPU asked for
  a_r2_store_byte_count: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_ram_wr |-> ($countones(ram_wr_be) == $countones(cpu_be)));

  // R6: one CPU access strobes at most one narrow target
  a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({rom_rd_en, dmac_rd_en, dmac_wr_en, intc_rd_en, intc_wr_en}));

endmodule

// File: tb/tb_soc_addr_router.sv
module tb_soc_addr_router;

  localparam int RAMB = 1024;
  localparam int ROMB = 4096;
  localparam int QW   = RAMB / 16;
  localparam int AW   = 6;
  localparam int RW   = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           cpu_req, cpu_we;
  logic [31:0]    cpu_addr, cpu_wdata;
  logic [3:0]     cpu_be;
  logic           cpu_rvalid;
  logic [31:0]    cpu_rdata;
  logic           dma_req, dma_gnt, dma_rvalid;
  logic [AW-1:0]  dma_qaddr;
  logic [127:0]   dma_rdata;
  logic           eg_req, eg_gnt;
  logic [AW-1:0]  eg_qaddr;
  logic [15:0]    eg_be;
  logic [127:0]   eg_data;
  logic           ram_rd_en, ram_wr_en;
  logic [AW-1:0]  ram_rd_addr, ram_wr_addr;
  logic [127:0]   ram_rd_data, ram_wr_data;
  logic [15:0]    ram_wr_be;
  logic           rom_rd_en;
  logic [RW-1:0]  rom_rd_addr;
  logic [31:0]    rom_rd_data;
  logic           dmac_rd_en, dmac_wr_en;
  logic [11:0]    dmac_off;
  logic [31:0]    dmac_wdata, dmac_rdata;
  logic           intc_rd_en, intc_wr_en, intc_sel;
  logic [31:0]    intc_wdata, intc_rdata;

  soc_addr_router #(.RAM_BYTES(RAMB), .ROM_BYTES(ROMB), .DW(128)) dut (.*);

  // ---------------- target models ----------------
  function automatic logic [127:0] seed_word(input int i);
    seed_word = {32'(i) * 32'h9E37_79B9, 32'(i) ^ 32'hA5A5_0000,
                 32'(i) * 32'h0101_0101 + 32'h1357, 32'hC0DE_0000 | 32'(i)};
  endfunction

  function automatic logic [31:0] rom_word(input logic [RW-1:0] a);
    rom_word = {8'hB0, 14'h0, a};
  endfunction

  localparam logic [31:0] INTC_STAT_VAL = 32'h0000_0004;
  localparam logic [31:0] INTC_MASK_VAL = 32'h0000_0F0F;

  logic [127:0] mem [QW];
  logic         init_go;

  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < QW; i++) mem[i] <= seed_word(i);
    end else if (ram_wr_en) begin
      for (int b = 0; b < 16; b++)
        if (ram_wr_be[b]) mem[ram_wr_addr][8*b +: 8] <= ram_wr_data[8*b +: 8];
    end
    if (ram_rd_en)  ram_rd_data <= mem[ram_rd_addr];
    if (rom_rd_en)  rom_rd_data <= rom_word(rom_rd_addr);
    if (dmac_rd_en) dmac_rdata  <= {20'hD0A00, dmac_off};
    if (intc_rd_en) intc_rdata  <= intc_sel ? INTC_MASK_VAL : INTC_STAT_VAL;
  end

  // ---------------- expected-value helpers ----------------
  logic [127:0] sh [QW];

  function automatic logic [127:0] merge_be(input logic [127:0] old_w,
                                            input logic [127:0] new_w,
                                            input logic [15:0] be);
    logic [127:0] r = old_w;
    for (int b = 0; b < 16; b++) if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  function automatic logic [15:0] wide_be(input logic [3:0] be, input logic [1:0] ln);
    logic [15:0] r = '0;
    r[4*ln +: 4] = be;
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    logic [28:0] p = a[28:0];
    if (p < 29'(RAMB))
      return sh[p[AW+3:4]][32*p[3:2] +: 32];
    if (p >= 29'h1FC0_0000 && p < 29'h1FC0_0000 + 29'(ROMB))
      return rom_word(p[RW+1:2]);
    if (p[28:12] == 17'h1_000A) return {20'hD0A00, p[11:0]};
    if (p[28:12] == 17'h1_000F && p[11:0] == 12'h000) return INTC_STAT_VAL;
    if (p[28:12] == 17'h1_000F && p[11:0] == 12'h010) return INTC_MASK_VAL;
    return 32'hDEAD_BEEF;
  endfunction

  // ---------------- scoring ----------------
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // strobes seen during the last CPU access cycle
  logic s_ram_rd, s_ram_wr, s_rom_rd, s_dmac_rd, s_dmac_wr, s_intc_rd, s_intc_wr, s_sel;
  logic [11:0]  s_off;
  logic [31:0]  s_regwd;
  logic [15:0]  s_be;
  logic [127:0] s_wd;

  task automatic snap;
    s_ram_rd = ram_rd_en;  s_ram_wr = ram_wr_en;  s_rom_rd = rom_rd_en;
    s_dmac_rd = dmac_rd_en; s_dmac_wr = dmac_wr_en;
    s_intc_rd = intc_rd_en; s_intc_wr = intc_wr_en; s_sel = intc_sel;
    s_off = dmac_off; s_regwd = dmac_wdata; s_be = ram_wr_be; s_wd = ram_wr_data;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cpu_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_be = 4'hF;
    #1 snap();
    @(negedge clk);
    cpu_req = 1'b0;
    chk(tag, cpu_rvalid ? cpu_rdata : 32'h0BAD_0BAD, exp);
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_be = be; cpu_wdata = d;
    #1 snap();
    if (a[28:0] < 29'(RAMB))
      sh[a[AW+3:4]] = merge_be(sh[a[AW+3:4]], {4{d}}, wide_be(be, a[3:2]));
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0]  seed_v;
    logic [127:0] egv;
    seed_v = $urandom(32'h5EED_0017);
    rst_n = 1'b0; init_go = 1'b1;
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_be = 0; cpu_wdata = 0;
    dma_req = 0; dma_qaddr = 0; eg_req = 0; eg_qaddr = 0; eg_be = 0; eg_data = 0;
    for (int i = 0; i < QW; i++) sh[i] = seed_word(i);
    repeat (3) @(negedge clk);
    init_go = 1'b0;
    // R12: valids low while reset is asserted
    chk("R12 cpu_rvalid in reset", cpu_rvalid, 1'b0);
    chk("R12 dma_rvalid in reset", dma_rvalid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 cpu_rvalid idle", cpu_rvalid, 1'b0);

    // R2/R1: single byte into lane 2, then every lane read back
    cpu_write(32'h0000_0078, 4'b0100, 32'hAABB_CCDD);
    chk("R2 be placement", s_be, 16'h0400);
    chk("R2 data replicated", s_wd, {4{32'hAABB_CCDD}});
    for (int l = 0; l < 4; l++)
      cpu_read(32'h0000_0070 | 32'(l << 2), sh[7][32*l +: 32], "R1/R2 lane readback");

    // R11: same location through three segments
    cpu_write(32'hA000_0030, 4'hF, 32'h1234_5678);
    cpu_read(32'h8000_0030, 32'h1234_5678, "R11 segment alias 8");
    cpu_read(32'h0000_0030, 32'h1234_5678, "R11 segment alias 0");

    // R3 + R5: CPU and DMA read in the same cycle
    cpu_req = 1; cpu_we = 0; cpu_addr = 32'h0000_0058; cpu_be = 4'hF;
    dma_req = 1; dma_qaddr = 6'd9;
    #1;
    chk("R3 dma_gnt refused", dma_gnt, 1'b0);
    chk("R3 cpu owns read addr", ram_rd_addr, 6'd5);
    @(negedge clk);
    cpu_req = 0;
    chk("R1 read under contention", cpu_rvalid ? cpu_rdata : 32'h0BAD_0BAD, sh[5][95:64]);
    #1 chk("R5 dma granted after contention", dma_gnt, 1'b1);
    @(negedge clk);
    dma_req = 0;
    chk("R5 dma data", dma_rvalid ? dma_rdata : 128'h0, sh[9]);

    // R4 + R5: CPU and egress write in the same cycle
    egv = {$urandom, $urandom, $urandom, $urandom};
    cpu_req = 1; cpu_we = 1; cpu_addr = 32'h0000_00C4; cpu_be = 4'hF; cpu_wdata = 32'h1122_3344;
    eg_req = 1; eg_qaddr = 6'd13; eg_be = 16'h00FF; eg_data = egv;
    #1;
    chk("R4 eg_gnt refused", eg_gnt, 1'b0);
    chk("R4 cpu owns write addr", ram_wr_addr, 6'd12);
    sh[12] = merge_be(sh[12], {4{32'h1122_3344}}, 16'h00F0);
    @(negedge clk);
    cpu_req = 0;
    #1 chk("R5 egress granted after contention", eg_gnt, 1'b1);
    sh[13] = merge_be(sh[13], egv, 16'h00FF);
    @(negedge clk);
    eg_req = 0;
    cpu_read(32'h0000_00C4, 32'h1122_3344, "R4 cpu write landed");
    for (int l = 0; l < 4; l++)
      cpu_read(32'h0000_00D0 | 32'(l << 2), sh[13][32*l +: 32], "R4/R5 egress masked write");

    // R5: DMA read and egress write together, no CPU
    egv = {$urandom, $urandom, $urandom, $urandom};
    dma_req = 1; dma_qaddr = 6'd20; eg_req = 1; eg_qaddr = 6'd21; eg_be = 16'hFFFF; eg_data = egv;
    #1;
    chk("R5 dma not blocked by egress", dma_gnt, 1'b1);
    chk("R5 egress not blocked by dma", eg_gnt, 1'b1);
    sh[21] = egv;
    @(negedge clk);
    dma_req = 0; eg_req = 0;
    chk("R5 dma data parallel", dma_rvalid ? dma_rdata : 128'h0, sh[20]);
    cpu_read(32'h0000_0158, sh[21][95:64], "R5 egress parallel write");

    // R6: DMA register page
    cpu_write(32'h1000_A020, 4'hF, 32'hCAFE_0001);
    chk("R6 dmac write strobe", {s_dmac_wr, s_dmac_rd, s_ram_wr}, 3'b100);
    chk("R6 dmac write offset", s_off, 12'h020);
    chk("R6 dmac write data", s_regwd, 32'hCAFE_0001);
    cpu_read(32'hB000_A040, 32'hD0A0_0040, "R6 dmac read");
    chk("R6 dmac read strobe", s_dmac_rd, 1'b1);

    // R7: interrupt page
    cpu_read(32'h1000_F000, INTC_STAT_VAL, "R7 status read");
    chk("R7 status select", {s_intc_rd, s_sel}, 2'b10);
    cpu_read(32'h1000_F010, INTC_MASK_VAL, "R7 mask read");
    chk("R7 mask select", {s_intc_rd, s_sel}, 2'b11);
    cpu_read(32'h1000_F004, 32'hDEAD_BEEF, "R7 other offset unmapped");
    chk("R7 other offset no strobe", s_intc_rd, 1'b0);
    cpu_write(32'h1000_F010, 4'hF, 32'h0000_0055);
    chk("R7 mask write", {s_intc_wr, s_sel}, 2'b11);

    // R8: unmapped
    cpu_read(32'h0500_0000, 32'hDEAD_BEEF, "R8 unmapped read");
    cpu_write(32'h0500_0000, 4'hF, 32'h1);
    chk("R8 unmapped write strobes", {s_ram_wr, s_dmac_wr, s_intc_wr}, 3'b000);

    // R9: boot ROM
    cpu_read(32'hBFC0_0000, rom_word(10'd0), "R9 rom reset vector");
    cpu_read(32'hBFC0_0124, rom_word(10'h49), "R9 rom word");
    cpu_read(32'hBFC0_0FFC, rom_word(10'h3FF), "R9 rom last word");
    cpu_write(32'hBFC0_0010, 4'hF, 32'h7);
    chk("R9 rom write strobes", {s_ram_wr, s_dmac_wr, s_intc_wr, s_rom_rd}, 4'b0000);

    // R10: RAM boundary
    cpu_read(32'h0000_03FC, sh[63][127:96], "R10 last RAM word");
    cpu_read(32'h0000_0400, 32'hDEAD_BEEF, "R10 past RAM end");
    chk("R10 no RAM read strobe", s_ram_rd, 1'b0);
    cpu_write(32'h8000_0400, 4'hF, 32'h9);
    chk("R10 no RAM write strobe", s_ram_wr, 1'b0);
    cpu_read(32'h0000_0000, sh[0][31:0], "R10 word 0 not aliased");

    // R1/R2/R11: constrained random RAM traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      logic [31:0] seg;
      seg = ($urandom % 3 == 0) ? 32'h0 : (($urandom % 2 == 0) ? 32'h8000_0000 : 32'hA000_0000);
      a = seg | 32'(($urandom % QW) << 4) | 32'(($urandom % 4) << 2);
      if ($urandom % 2 == 0) cpu_write(a, 4'($urandom), $urandom);
      else cpu_read(a, exp_read(a), "R1/R2 random RAM");
    end

    // R6/R7/R8/R9/R10: random reads across address classes
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a;
      case ($urandom % 6)
        0: a = 32'h0000_0000 | 32'(($urandom % RAMB) & ~3);
        1: a = 32'hBFC0_0000 | 32'(($urandom % ROMB) & ~3);
        2: a = 32'h1000_A000 | 32'(($urandom % 4096) & ~3);
        3: a = 32'h1000_F000 | 32'(($urandom % 3) << 3);
        4: a = 32'h0000_0400 + 32'(($urandom % 4096) & ~3);
        default: a = {3'($urandom), 29'($urandom)} & ~32'h3;
      endcase
      cpu_read(a, exp_read(a), "R6-class random decode");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule